// File: doc/BRIEF.md
# Multicycle Stored-Program Control Unit

This block is a small 16-bit register machine whose control is a multicycle state machine. Every instruction walks through a subset of six phases (fetch, decode, address evaluation, operand fetch, execute, store), and an instruction that needs fewer phases takes fewer cycles. The machine reaches a single-port word memory only through a memory address register (MAR) and a memory data register (MDR), pulsing a read strobe. Read data arrives on `mem_rdata` one cycle after the strobe.

Five operations are supported: register ADD, AND and NOT; a load that adds a signed offset to a base register; and a jump that takes the new program counter from a register. Any other opcode passes through decode and returns to fetch. A synchronous `run_en` input freezes every state element and suppresses the read strobe while low.

The states are `ST_FETCH_MAR` (MAR takes PC), `ST_FETCH_RD` (read strobe), `ST_FETCH_MDR` (MDR captures memory), `ST_FETCH_IR` (IR takes MDR, PC steps by one), `ST_DECODE`, `ST_EVAL_ADDR` (MAR takes base plus offset), `ST_OPND_RD`, `ST_OPND_MDR`, `ST_OPND_REG` (ALU operands latched from the register file), `ST_EXECUTE` (ALU result latched, or PC loaded for a jump) and `ST_STORE` (destination register written). The transitions are:
- The fetch states run in a fixed chain: MAR, RD, MDR, IR, then DECODE.
- DECODE goes to OPND_REG for ADD, AND and NOT, to EVAL_ADDR for a load, and to EXECUTE for a jump. Any other opcode goes back to FETCH_MAR.
- The load path runs EVAL_ADDR, OPND_RD, OPND_MDR, then STORE.
- The ALU path runs OPND_REG, EXECUTE, then STORE.
- After a jump, EXECUTE returns to FETCH_MAR.
- STORE returns to FETCH_MAR.

Top module: `phase_cpu`

## Requirements
- R1: After reset, PC is 0, all eight registers are 0, and the machine starts in fetch. The first read strobe appears in cycle 1, counting the first cycle after reset release as cycle 0, with `mem_addr` = 0.
- R2: Each fetch drives the PC onto `mem_addr` with a read strobe. The fetch loads the returned word into the instruction register, and the next fetch reads from PC+1 unless a jump intervened.
- R3: Opcode 4'b0001 (ADD) writes IR[8:6] + IR[2:0], taken as register contents modulo 2^16, into register IR[11:9].
- R4: Opcode 4'b0101 (AND) writes the bitwise AND of registers IR[8:6] and IR[2:0] into register IR[11:9].
- R5: Opcode 4'b1001 (NOT) writes the bitwise complement of register IR[8:6] into register IR[11:9]. Bits IR[5:0] have no effect on the result.
- R6: Opcode 4'b0110 (load) reads memory at register IR[8:6] plus IR[5:0] sign-extended to 16 bits. The load puts the word into register IR[11:9].
- R7: Opcode 4'b1100 (jump) sets PC to register IR[8:6], and the next fetch reads from that address.
- R8: Cycles from one fetch read strobe to the next are 8 for ADD, AND and NOT, 9 for a load, 6 for a jump and 5 for any other opcode.
- R9: Every opcode other than the five above changes no register and no PC beyond the fetch increment.
- R10: While `run_en` is low, no read strobe is issued and `mem_addr` holds still. When `run_en` returns, execution resumes where it stopped, and completion is delayed by exactly the number of halted cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; low freezes all state |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory address, driven from MAR |
| mem_rdata | input | 16 | Read data, valid one cycle after the strobe |

## Verification
Register contents are read back through the address bus. Each test ends in a jump through the register under test, so the address of the next fetch reveals the value. The ALU operations are swept over every pair drawn from eight edge values (zero, one, both sign boundaries, all ones, alternating patterns), which separates carry behaviour, AND and NOT from each other and from a pass-through. Loads use negative and maximum positive offsets to tell sign extension apart from zero extension. All eleven unused opcodes are tried against a live destination register, and halts placed in a read state and inside an ALU sequence show whether freezing drops or repeats a phase.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
    localparam int WORD_W = 16;
    localparam int REG_N  = 8;
    localparam int RIDX_W = $clog2(REG_N);
    localparam int OPC_W  = 4;
    localparam int OFF_W  = 6;
    localparam int OPC_N  = 1 << OPC_W;

    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;
    localparam logic [OPC_W-1:0] OPC_LDR = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_JMP = 4'b1100;

    typedef enum logic [3:0] {
        ST_FETCH_MAR,
        ST_FETCH_RD,
        ST_FETCH_MDR,
        ST_FETCH_IR,
        ST_DECODE,
        ST_EVAL_ADDR,
        ST_OPND_RD,
        ST_OPND_MDR,
        ST_OPND_REG,
        ST_EXECUTE,
        ST_STORE
    } phase_t;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_AND,
        ALU_NOT
    } alu_op_t;
endpackage

// File: rtl/op_decoder.sv
module op_decoder
    import cpu_pkg::*;
#(
    parameter int IN_W = OPC_W
) (
    input  logic [IN_W-1:0]       code,
    output logic [(1<<IN_W)-1:0]  hot
);
    genvar g;
    generate
        for (g = 0; g < (1 << IN_W); g++) begin : g_line
            assign hot[g] = (code == g[IN_W-1:0]);
        end
    endgenerate
endmodule

// File: rtl/reg_file.sv
module reg_file
    import cpu_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int N = REG_N,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [IW-1:0] ra,
    input  logic [IW-1:0] rb,
    output logic [W-1:0]  qa,
    output logic [W-1:0]  qb
);
    logic [W-1:0] cells [N];

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cells[g] <= '0;
                end else if (we && wa == g[IW-1:0]) begin
                    cells[g] <= wd;
                end
            end
        end
    endgenerate

    assign qa = cells[ra];
    assign qb = cells[rb];
endmodule

// File: rtl/alu.sv
module alu
    import cpu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  alu_op_t      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_AND: y = a & b;
            ALU_NOT: y = ~a;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/ctrl_fsm.sv
module ctrl_fsm
    import cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [OPC_N-1:0] opc_hot,
    output phase_t           state,
    output logic             mar_from_pc,
    output logic             mar_from_ea,
    output logic             mem_rd,
    output logic             mdr_load,
    output logic             ir_load,
    output logic             pc_inc,
    output logic             pc_jump,
    output logic             opnd_load,
    output logic             res_load,
    output logic             rf_we
);
    phase_t nxt;
    logic   is_alu, is_ldr, is_jmp;

    assign is_alu = opc_hot[OPC_ADD] | opc_hot[OPC_AND] | opc_hot[OPC_NOT];
    assign is_ldr = opc_hot[OPC_LDR];
    assign is_jmp = opc_hot[OPC_JMP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FETCH_MAR;
        end else if (run_en) begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt         = state;
        mar_from_pc = 1'b0;
        mar_from_ea = 1'b0;
        mem_rd      = 1'b0;
        mdr_load    = 1'b0;
        ir_load     = 1'b0;
        pc_inc      = 1'b0;
        pc_jump     = 1'b0;
        opnd_load   = 1'b0;
        res_load    = 1'b0;
        rf_we       = 1'b0;
        unique case (state)
            ST_FETCH_MAR: begin
                mar_from_pc = run_en;
                nxt = ST_FETCH_RD;
            end
            ST_FETCH_RD: begin
                mem_rd = run_en;
                nxt = ST_FETCH_MDR;
            end
            ST_FETCH_MDR: begin
                mdr_load = run_en;
                nxt = ST_FETCH_IR;
            end
            ST_FETCH_IR: begin
                ir_load = run_en;
                pc_inc  = run_en;
                nxt = ST_DECODE;
            end
            ST_DECODE: begin
                if (is_alu)      nxt = ST_OPND_REG;
                else if (is_ldr) nxt = ST_EVAL_ADDR;
                else if (is_jmp) nxt = ST_EXECUTE;
                else             nxt = ST_FETCH_MAR;
            end
            ST_EVAL_ADDR: begin
                mar_from_ea = run_en;
                nxt = ST_OPND_RD;
            end
            ST_OPND_RD: begin
                mem_rd = run_en;
                nxt = ST_OPND_MDR;
            end
            ST_OPND_MDR: begin
                mdr_load = run_en;
                nxt = ST_STORE;
            end
            ST_OPND_REG: begin
                opnd_load = run_en;
                nxt = ST_EXECUTE;
            end
            ST_EXECUTE: begin
                if (is_jmp) begin
                    pc_jump = run_en;
                    nxt = ST_FETCH_MAR;
                end else begin
                    res_load = run_en;
                    nxt = ST_STORE;
                end
            end
            ST_STORE: begin
                rf_we = run_en;
                nxt = ST_FETCH_MAR;
            end
            default: nxt = ST_FETCH_MAR;
        endcase
    end

    assert_halt_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (state == $past(state)));

    assert_fetch_chain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && state == ST_FETCH_IR) |=> (state == ST_DECODE));
endmodule

// File: rtl/phase_cpu.sv
module phase_cpu
    import cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    output logic              mem_rd,
    output logic [WORD_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata
);
    logic [WORD_W-1:0] pc, ir, mar, mdr, opa, opb, res;
    logic [WORD_W-1:0] rf_a, rf_b, alu_y, ea, wb_data;
    logic [OPC_N-1:0]  opc_hot;
    phase_t            state;
    alu_op_t           aop;
    logic mar_from_pc, mar_from_ea, mdr_load, ir_load, pc_inc, pc_jump;
    logic opnd_load, res_load, rf_we;

    op_decoder #(.IN_W(OPC_W)) u_dec (
        .code (ir[WORD_W-1 -: OPC_W]),
        .hot  (opc_hot)
    );

    ctrl_fsm u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .opc_hot     (opc_hot),
        .state       (state),
        .mar_from_pc (mar_from_pc),
        .mar_from_ea (mar_from_ea),
        .mem_rd      (mem_rd),
        .mdr_load    (mdr_load),
        .ir_load     (ir_load),
        .pc_inc      (pc_inc),
        .pc_jump     (pc_jump),
        .opnd_load   (opnd_load),
        .res_load    (res_load),
        .rf_we       (rf_we)
    );

    assign wb_data = opc_hot[OPC_LDR] ? mdr : res;

    reg_file #(.W(WORD_W), .N(REG_N)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .wa    (ir[11:9]),
        .wd    (wb_data),
        .ra    (ir[8:6]),
        .rb    (ir[2:0]),
        .qa    (rf_a),
        .qb    (rf_b)
    );

    always_comb begin
        if (opc_hot[OPC_AND])      aop = ALU_AND;
        else if (opc_hot[OPC_NOT]) aop = ALU_NOT;
        else                       aop = ALU_ADD;
    end

    alu #(.W(WORD_W)) u_alu (
        .op (aop),
        .a  (opa),
        .b  (opb),
        .y  (alu_y)
    );

    assign ea = rf_a + {{(WORD_W-OFF_W){ir[OFF_W-1]}}, ir[OFF_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc  <= '0;
            ir  <= '0;
            mar <= '0;
            mdr <= '0;
            opa <= '0;
            opb <= '0;
            res <= '0;
        end else begin
            if (mar_from_pc)      mar <= pc;
            else if (mar_from_ea) mar <= ea;
            if (mdr_load)         mdr <= mem_rdata;
            if (ir_load)          ir  <= mdr;
            if (pc_inc)           pc  <= pc + 1'b1;
            else if (pc_jump)     pc  <= rf_a;
            if (opnd_load) begin
                opa <= rf_a;
                opb <= rf_b;
            end
            if (res_load)         res <= alu_y;
        end
    end

    assign mem_addr = mar;

    assert_mar_takes_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && state == ST_FETCH_MAR) |=> (mar == $past(pc)));

    assert_ir_from_mdr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && state == ST_FETCH_IR) |=> (ir == $past(mdr) && pc == $past(pc) + 16'd1));

    assert_jump_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && state == ST_EXECUTE && opc_hot[OPC_JMP]) |=> (pc == $past(rf_a)));

    assert_decode_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(opc_hot) == 1);

    assert_halt_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(mem_addr));
endmodule

// File: tb/sim_phase_cpu.sv
module sim_phase_cpu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b1;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = 16'h0;
    logic [15:0] mem_img [64];
    logic [15:0] exp_rd [8];
    int n_chk = 0;
    int n_bad = 0;

    always #4ns clk = ~clk;

    phase_cpu u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (mem_rd) mem_rdata <= (mem_addr < 16'd64) ? mem_img[mem_addr[5:0]] : 16'h0000;
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input logic [3:0] op, input int d, input int s, input logic [5:0] lo);
        return {op, d[2:0], s[2:0], lo};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem_img[i] = 16'h0;
    endtask

    // Runs from reset until read number tgt_idx; exp_rd holds expected read addresses.
    task automatic run_case(input string rq, input int tgt_idx, input int exp_cyc,
                            input int halt_at, input int halt_len);
        int cyc, nrd;
        bit done, halt_bad;
        logic [15:0] held;
        rst_n = 1'b0;
        run_en = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cyc = 0; nrd = 0; done = 0; halt_bad = 0; held = 16'h0;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (halt_len > 0 && cyc > halt_at && cyc <= halt_at + halt_len) begin
                if (cyc == halt_at + 1) held = mem_addr;
                if (mem_rd || mem_addr !== held) halt_bad = 1;
            end
            if (mem_rd) begin
                if (nrd == 0) chk({rq, " R1 first read cycle"}, cyc, 1);
                chk({rq, " R2 read address"}, mem_addr, exp_rd[nrd]);
                if (nrd == tgt_idx) begin
                    chk({rq, " R8 completion cycle"}, cyc, exp_cyc);
                    done = 1;
                end
                nrd++;
            end
            if (halt_len > 0 && cyc == halt_at) run_en = 1'b0;
            if (halt_len > 0 && cyc == halt_at + halt_len) run_en = 1'b1;
        end
        if (!done) chk({rq, " timeout"}, 0, 1);
        if (halt_len > 0) chk({rq, " R10 frozen while halted"}, halt_bad, 0);
        run_en = 1'b1;
    endtask

    task automatic alu_case(input int sel, input logic [15:0] a, input logic [15:0] b,
                            input logic [5:0] lo, input int halt_at, input int halt_len);
        logic [15:0] r;
        logic [3:0]  op;
        string rq;
        clear_mem();
        case (sel)
            0: begin op = 4'b0001; r = a + b;  rq = "R3 ADD"; end
            1: begin op = 4'b0101; r = a & b;  rq = "R4 AND"; end
            default: begin op = 4'b1001; r = ~a; rq = "R5 NOT"; end
        endcase
        mem_img[0]  = enc(4'b0110, 1, 0, 6'd20);
        mem_img[1]  = enc(4'b0110, 2, 0, 6'd21);
        mem_img[2]  = enc(op, 3, 1, lo);
        mem_img[3]  = enc(4'b1100, 0, 3, 6'd0);
        mem_img[20] = a;
        mem_img[21] = b;
        exp_rd[0] = 16'd0; exp_rd[1] = 16'd20; exp_rd[2] = 16'd1; exp_rd[3] = 16'd21;
        exp_rd[4] = 16'd2; exp_rd[5] = 16'd3;  exp_rd[6] = r;     exp_rd[7] = 16'd0;
        // reads at 1, 10, 19 (two loads), ALU 8 cycles, jump 6 cycles
        run_case(rq, 6, 33 + halt_len, halt_at, halt_len);
    endtask

    initial begin : watchdog
        #1600us;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin : main
        logic [15:0] vals [8];
        logic [3:0]  unused [11];
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
        vals[4] = 16'hFFFF; vals[5] = 16'h1234; vals[6] = 16'hAAAA; vals[7] = 16'h5555;
        unused[0] = 4'd0;  unused[1] = 4'd2;  unused[2] = 4'd3;  unused[3] = 4'd4;
        unused[4] = 4'd7;  unused[5] = 4'd8;  unused[6] = 4'd10; unused[7] = 4'd11;
        unused[8] = 4'd13; unused[9] = 4'd14; unused[10] = 4'd15;

        clear_mem();
        repeat (2) @(negedge clk);
        chk("R1 reset mem_rd", mem_rd, 0);
        chk("R1 reset address", mem_addr, 0);

        // R3 R4 R5: full sweep of operand pairs
        for (int s = 0; s < 3; s++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    alu_case(s, vals[i], vals[j], (s == 2) ? 6'h3F : 6'd2, 0, 0);

        // R5: low bits of NOT have no effect
        for (int i = 0; i < 8; i++) alu_case(2, vals[i], 16'h0, 6'h02, 0, 0);

        // R6: load with negative and maximal positive offset
        for (int k = 0; k < 2; k++) begin
            logic [5:0]  off;
            logic [15:0] ad, v;
            off = (k == 0) ? 6'b111011 : 6'd31;
            ad  = (k == 0) ? 16'd25 : 16'd61;
            v   = (k == 0) ? 16'hBEEF : 16'h8001;
            clear_mem();
            mem_img[0]  = enc(4'b0110, 1, 0, 6'd20);
            mem_img[1]  = enc(4'b0110, 2, 1, off);
            mem_img[2]  = enc(4'b1100, 0, 2, 6'd0);
            mem_img[20] = 16'd30;
            mem_img[ad[5:0]] = v;
            exp_rd[0] = 16'd0; exp_rd[1] = 16'd20; exp_rd[2] = 16'd1;
            exp_rd[3] = ad;    exp_rd[4] = 16'd2;  exp_rd[5] = v;
            exp_rd[6] = 16'd0; exp_rd[7] = 16'd0;
            run_case("R6 load offset", 5, 25, 0, 0);
        end

        // R7 R9: unused opcodes leave R3 and PC flow alone
        for (int u = 0; u < 11; u++) begin
            clear_mem();
            mem_img[0]  = enc(4'b0110, 3, 0, 6'd20);
            mem_img[1]  = enc(4'b0110, 1, 0, 6'd21);
            mem_img[2]  = enc(unused[u], 3, 1, 6'd1);
            mem_img[3]  = enc(4'b1100, 0, 3, 6'd0);
            mem_img[20] = 16'h0C3A;
            mem_img[21] = 16'h1111;
            exp_rd[0] = 16'd0; exp_rd[1] = 16'd20; exp_rd[2] = 16'd1; exp_rd[3] = 16'd21;
            exp_rd[4] = 16'd2; exp_rd[5] = 16'd3;  exp_rd[6] = 16'h0C3A; exp_rd[7] = 16'd0;
            run_case("R9 unused opcode", 6, 30, 0, 0);
        end

        // R10: halts in a read state and inside the ALU sequence
        alu_case(0, 16'h1234, 16'h4321, 6'd2, 9, 5);
        alu_case(1, 16'hF0F0, 16'h3C3C, 6'd2, 22, 3);
        alu_case(2, 16'h00FF, 16'h0, 6'h3F, 12, 7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule